// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits between a serial receiver and the write port of a receive FIFO. It counts the bytes of the current frame in a 13-bit up-counter and compares the count against a maximum length that software programs. While a frame stays within the limit, every received byte passes straight to the FIFO write port. The first byte that would take the frame past the limit is dropped. From that byte on, FIFO writes stay blocked, and a sticky overflow status bit is raised.

Writes are re-enabled only when the physical layer reports the start flag of a new frame. That indication also restarts the count. Software reads the running byte count through the same two byte-wide register slots it uses to write the limit. It clears the status bit with a dedicated input.

Top module: `rx_frame_len_guard`

## Requirements
- R1: The limit is 13 bits wide and is written through two byte slots. With `reg_sel_i`=0 a write loads limit bits 7..0. With `reg_sel_i`=1 a write loads limit bits 12..8 from `reg_wdata_i[4:0]`, and bits 7..5 of that write are ignored. Both parts reset to 0.
- R2: Each cycle with `byte_vld_i`=1 adds one to the frame byte count, whether or not the byte is written. A read with `reg_sel_i`=0 returns count bits 7..0 on `reg_rdata_o` in the same cycle. A read with `reg_sel_i`=1 returns `{3'b000, count[12:8]}`.
- R3: While the frame is within the limit, `fifo_we_o` equals `byte_vld_i` in the same cycle, and `fifo_wdata_o` carries `byte_i`.
- R4: With a non-zero limit L, byte number L+1 of a frame is not written. The status output `ovf_o` reads 1 from the next cycle on.
- R5: After the limit is exceeded, no further byte of that frame is written. The byte that arrives together with `sof_i`=1 is written, and it counts as byte 1 of the new frame.
- R6: `ovf_o` stays 1 until a cycle with `ovf_clr_i`=1, and it reads 0 after that cycle. A start flag does not clear it. If an overflow occurs in the same cycle as the clear, the set wins.
- R7: A limit of 0 disables the check: every received byte is written and `ovf_o` is never set.
- R8: The count saturates at 8191 and does not wrap.
- R9: `sof_i`=1 without a byte resets the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start flag of a new frame seen |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| fifo_we_o | output | 1 | Gated FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Byte slot select: 0 low, 1 high |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected byte of the frame byte count |
| ovf_o | output | 1 | Sticky maximum-length-exceeded status |
| ovf_clr_i | input | 1 | Clears the status bit |

## Verification
The write strobe, the write data and the count readback are combinational. The bench samples them one time unit after it drives the inputs at the falling edge, inside the same cycle. The counter, the discard state and `ovf_o` change at the next rising edge. Their effects are therefore sampled at the falling edge that follows. A sweep over small limits and frame lengths derives every expected strobe from the byte index against the limit. Two long frames reach the 8191 saturation point, with and without the check enabled.

// File: rtl/rx_frame_len_guard.sv
module rx_frame_len_guard #(
  parameter int CNT_W  = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              fifo_we_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lim_q, cnt_q, cnt_base;
  logic             drop_q, drop_base, over_now;

  assign cnt_base  = sof_i ? '0 : cnt_q;
  assign drop_base = sof_i ? 1'b0 : drop_q;
  assign over_now  = byte_vld_i && (lim_q != '0) && (cnt_base >= lim_q);

  assign fifo_we_o    = byte_vld_i && !drop_base && !over_now;
  assign fifo_wdata_o = byte_i;
  assign reg_rdata_o  = reg_sel_i ? DATA_W'({cnt_q[CNT_W-1:DATA_W]})
                                  : cnt_q[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_sel_i) lim_q[CNT_W-1:DATA_W] <= reg_wdata_i[HI_W-1:0];
      else           lim_q[DATA_W-1:0]     <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      if (byte_vld_i)
        cnt_q <= (cnt_base == CNT_MAX) ? CNT_MAX : cnt_base + 1'b1;
      else
        cnt_q <= cnt_base;
      drop_q <= drop_base || over_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_o <= 1'b0;
    else if (over_now)   ovf_o <= 1'b1;
    else if (ovf_clr_i)  ovf_o <= 1'b0;
  end
endmodule

// File: rtl/rx_frame_len_guard_chk.sv
module rx_frame_len_guard_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof_i,
  input logic             byte_vld_i,
  input logic             fifo_we_o,
  input logic             ovf_o,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] lim_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3
  we_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we_o |-> byte_vld_i);

  // R4
  ovf_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(byte_vld_i && !fifo_we_o));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  // R7
  no_limit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) && byte_vld_i |-> fifo_we_o);

  // R8
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i && !sof_i && (cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i && !sof_i && (cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R9
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i && !byte_vld_i |=> cnt_q == '0);
endmodule

bind rx_frame_len_guard rx_frame_len_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
  .fifo_we_o(fifo_we_o), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i),
  .lim_q(lim_q), .cnt_q(cnt_q)
);

// File: tb/rx_frame_len_guard_tb.sv
module rx_frame_len_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, vld = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0, clr = 1'b0;
  logic [7:0] din = '0, reg_wd = '0;
  logic       we, ovf;
  logic [7:0] wd, rd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_frame_len_guard u_dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(din),
    .fifo_we_o(we), .fifo_wdata_o(wd), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wd), .reg_rdata_o(rd), .ovf_o(ovf), .ovf_clr_i(clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] d,
                      input logic c, output logic w, output logic [7:0] wdo);
    @(negedge clk);
    vld = v; sof = s; din = d; clr = c;
    #1 w = we; wdo = wd;
    @(posedge clk);
    #1 vld = 0; sof = 0; clr = 0;
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wd = val;
    @(posedge clk);
    #1 reg_wr = 0;
  endtask

  task automatic set_lim(input int l);
    wr_reg(1'b0, 8'(l));
    wr_reg(1'b1, 8'(l >> 8));
  endtask

  task automatic rd_cnt(output int c);
    logic [7:0] lo;
    @(negedge clk);
    reg_sel = 0; #1 lo = rd;
    reg_sel = 1; #1 c = {rd, lo};
  endtask

  // Sends a frame of n bytes, first one with the start flag; checks each strobe.
  task automatic frame(input int lim, input int n, input logic c);
    logic w; logic [7:0] d;
    for (int k = 1; k <= n; k++) begin
      step(1'b1, k == 1, 8'(k * 7 + lim), c, w, d);
      if (lim == 0) chk("R7 write with zero limit", w, 1);
      else if (k <= lim) chk("R3 write within limit", w, 1);
      else if (k == lim + 1) chk("R4 exceeding byte dropped", w, 0);
      else chk("R5 later byte dropped", w, 0);
      if (w) chk("R3 data passthrough", d, (k * 7 + lim) & 8'hff);
    end
  endtask

  initial begin
    int c;
    logic w; logic [7:0] d;
    #10 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset write strobe", we, 0);
    chk("R6 reset status", ovf, 0);
    rd_cnt(c); chk("R2 reset count", c, 0);

    // Limit resets to 0: a long frame passes and no overflow is flagged
    frame(0, 12, 1'b0);
    @(negedge clk); #1 chk("R1 reset limit disables check", ovf, 0);
    rd_cnt(c); chk("R2 count after 12 bytes", c, 12);

    for (int lim = 0; lim <= 5; lim++) begin
      set_lim(lim);
      for (int n = 0; n <= 8; n++) begin
        if (n == 0) step(1'b0, 1'b1, 8'h00, 1'b0, w, d);
        else frame(lim, n, 1'b0);
        rd_cnt(c); chk("R2 frame count", c, n);
        chk("R4 status after frame", ovf, (lim != 0 && n > lim) ? 1 : 0);
        step(1'b0, 1'b1, 8'h00, 1'b0, w, d);
        rd_cnt(c); chk("R9 start flag clears count", c, 0);
        chk("R6 start flag keeps status", ovf, (lim != 0 && n > lim) ? 1 : 0);
        step(1'b0, 1'b0, 8'h00, 1'b1, w, d);
        @(negedge clk); #1 chk("R6 clear drops status", ovf, 0);
      end
    end

    // Re-arm: the start-flag byte after an overflow is written as byte 1
    set_lim(2);
    frame(2, 5, 1'b0);
    step(1'b1, 1'b1, 8'h5a, 1'b0, w, d);
    chk("R5 start-flag byte written after overflow", w, 1);
    chk("R5 start-flag byte data", d, 8'h5a);
    rd_cnt(c); chk("R5 new frame counts from 1", c, 1);
    step(1'b0, 1'b0, 8'h00, 1'b1, w, d);

    // Set wins over a simultaneous clear
    frame(2, 3, 1'b1);
    @(negedge clk); #1 chk("R6 set wins over clear", ovf, 1);
    step(1'b0, 1'b0, 8'h00, 1'b1, w, d);

    // High byte bits 7..5 ignored: 0xFF -> limit 0x1FFF; saturation
    wr_reg(1'b0, 8'hff);
    wr_reg(1'b1, 8'hff);
    for (int k = 1; k <= 8195; k++) begin
      step(1'b1, k == 1, 8'(k), 1'b0, w, d);
      if (k == 8191) chk("R1 byte 8191 written at max limit", w, 1);
      if (k == 8192) chk("R4 byte 8192 dropped at max limit", w, 0);
    end
    rd_cnt(c); chk("R8 count saturates with limit", c, 8191);
    @(negedge clk); #1 chk("R4 overflow at max limit", ovf, 1);
    step(1'b0, 1'b0, 8'h00, 1'b1, w, d);

    set_lim(0);
    for (int k = 1; k <= 8195; k++) begin
      step(1'b1, k == 1, 8'(k), 1'b0, w, d);
      if (k >= 8191) chk("R7 long frame written", w, 1);
    end
    rd_cnt(c); chk("R8 count saturates without limit", c, 8191);
    @(negedge clk); #1 chk("R7 no overflow with zero limit", ovf, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule